// File: doc/BRIEF.md
# Word-Tagged Instruction Fetch Cache

This block sits between a processor's 32-bit instruction fetch port and a word-wide memory. It holds 4 KiB of instruction words in a direct-mapped store in which every word slot carries its own 24-bit address tag. A fetch looks up one slot by address bits [11:2]. If the slot's tag equals bits [23:0] of the fetch address, the stored word is returned and memory is not touched. On a miss the aligned four-word line around the address is read from memory one word at a time and written into the store. The requested word is then returned.

Only addresses whose top byte is 0x00 or 0x80 are cached. Because the tag ignores the top byte, those two regions alias onto the same words. Every other address reads memory once and leaves the store untouched. After reset, and on a flush request, a sequencer writes all-ones into every tag and data slot, one slot per clock. An all-ones tag can never equal the tag of a word-aligned address, so every lookup misses until the slot is refilled. Fetch addresses are word aligned, with bits [1:0] zero.

Top module: `fetch_word_cache`

## Requirements
- R1: While reset is asserted, and while the wipe that follows reset is running, fetch_ready and mem_req stay low. The first fetch after reset misses and reads four words from memory.
- R2: An address is cacheable exactly when bits [31:24] equal 0x00 or 0x80.
- R3: A cacheable miss issues four reads in increasing order: the fetch address with bits [3:0] cleared, then that address plus 4, plus 8 and plus 12. Each read keeps mem_req high and mem_addr stable until mem_valid. Each word is stored in the slot selected by its own address bits [11:2], with its own address bits [23:0] as its tag.
- R4: The requester holds fetch_valid and fetch_addr until fetch_ready. fetch_ready is high for exactly one cycle, and fetch_data carries the word at the fetch address during that cycle.
- R5: When the slot's tag matches, fetch_ready rises in the cycle after the fetch is accepted and no memory read occurs.
- R6: Tags ignore address bits [31:24]. A word filled through a 0x00 address hits for the same offset under 0x80, and the reverse also holds. The word returned is the stored copy.
- R7: A cacheable fetch whose bits [11:2] select a slot holding a different bits [23:12] misses, refills the line and replaces those slots.
- R8: A non-cacheable fetch makes exactly one read at the exact fetch address and returns that word. It changes no slot, and it goes to memory even when a matching tag is stored.
- R9: A one-cycle flush_req wipes every slot, so later fetches miss. A flush requested while a fetch is in flight is remembered and carried out after that fetch is answered.
- R10: A wipe writes one slot per cycle over all 1024 slots. A fetch raised during a wipe waits at least 1024 cycles for its answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch request, held until fetch_ready |
| fetch_addr | input | 32 | Word-aligned fetch byte address |
| fetch_ready | output | 1 | One-cycle answer strobe |
| fetch_data | output | 32 | Instruction word, valid with fetch_ready |
| flush_req | input | 1 | Request to invalidate every slot |
| mem_req | output | 1 | Memory read request, held until mem_valid |
| mem_addr | output | 32 | Memory read byte address |
| mem_valid | input | 1 | Memory read data strobe |
| mem_data | input | 32 | Memory read data |

## Verification
The bench targets several corner cases, each with a typical failure mode:
- Top-byte aliasing: a design that put bits [31:24] into the tag would miss on an aliased fetch and make extra reads.
- Index conflicts: a design that compared too few tag bits would return a stale word from another line.
- Bypass of an address whose tag is already stored: a design that checked the tag before the region would return cached data without touching memory.
- Fill order and the requested word in the middle of a line: a wrong counter would show up in the logged read addresses or in the data returned.
- Flush: a design that dropped a flush raised during a miss would keep serving hits afterwards. A wipe that skipped slots or ran too short would answer in fewer than 1024 cycles.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 12;  // byte index bits of the store
  localparam int TAG_W      = 24;  // per-word tag width
  localparam int LINE_WORDS = 4;

  typedef enum logic [2:0] {
    ST_WIPE,
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_BYPASS,
    ST_RESPOND
  } seq_state_t;
endpackage

// File: rtl/fwc_region.sv
module fwc_region #(
  parameter int                 NUM_REGIONS = 2,
  parameter logic [NUM_REGIONS*8-1:0] REGION_LIST = 16'h8000
) (
  input  logic [7:0] top_byte,
  output logic       cacheable
);
  logic [NUM_REGIONS-1:0] match_vec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign match_vec[g] = (top_byte == REGION_LIST[g*8 +: 8]);
  end

  assign cacheable = |match_vec;
endmodule

// File: rtl/fwc_store.sv
module fwc_store #(
  parameter int WIDX_W = 10,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << WIDX_W;

  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [DATA_W-1:0] dat_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      dat_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_tag  <= '1;
      rd_data <= '1;
    end else if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_data <= dat_mem[rd_idx];
    end
  end

  // A real tag must land in the slot its own word-address bits select.
  assert_tag_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_tag != '1)) |-> (wr_tag[WIDX_W+1:2] == wr_idx));
endmodule

// File: rtl/fwc_seq.sv
module fwc_seq
  import fwc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 12,
  parameter int TAG_W      = 24,
  parameter int LINE_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid,
  input  logic [ADDR_W-1:0]   fetch_addr,
  output logic                fetch_ready,
  output logic [DATA_W-1:0]   fetch_data,
  input  logic                flush_req,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_valid,
  input  logic [DATA_W-1:0]   mem_data,
  output logic [ADDR_W-1:0]   req_addr,
  input  logic                req_cacheable,
  output logic                rd_en,
  output logic [IDX_W-3:0]    rd_idx,
  input  logic [TAG_W-1:0]    rd_tag,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                wr_en,
  output logic [IDX_W-3:0]    wr_idx,
  output logic [TAG_W-1:0]    wr_tag,
  output logic [DATA_W-1:0]   wr_data
);
  localparam int WIDX_W     = IDX_W - 2;
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam int LINE_SHIFT = OFF_W + 2;

  seq_state_t        state_q, state_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] resp_q, resp_d;
  logic [WIDX_W-1:0] wipe_q, wipe_d;
  logic              pend_q, pend_d;
  logic              tag_hit;

  assign req_addr = addr_q;
  assign tag_hit  = (rd_tag == addr_q[TAG_W-1:0]);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    addr_d      = addr_q;
    resp_d      = resp_q;
    wipe_d      = wipe_q;
    pend_d      = pend_q | flush_req;
    rd_en       = 1'b0;
    rd_idx      = fetch_addr[IDX_W-1:2];
    wr_en       = 1'b0;
    wr_idx      = wipe_q;
    wr_tag      = '1;
    wr_data     = '1;
    mem_req     = 1'b0;
    mem_addr    = addr_q;
    fetch_ready = 1'b0;
    fetch_data  = resp_q;
    case (state_q)
      ST_WIPE: begin
        wr_en  = 1'b1;
        wipe_d = wipe_q + 1'b1;
        pend_d = 1'b0;
        if (&wipe_q) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (pend_q || flush_req) begin
          state_d = ST_WIPE;
          wipe_d  = '0;
        end else if (fetch_valid) begin
          addr_d  = fetch_addr;
          rd_en   = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (!req_cacheable) begin
          state_d = ST_BYPASS;
        end else if (tag_hit) begin
          fetch_ready = 1'b1;
          fetch_data  = rd_data;
          state_d     = ST_IDLE;
        end else begin
          cnt_d   = '0;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {addr_q[ADDR_W-1:LINE_SHIFT], cnt_q, 2'b00};
        if (mem_valid) begin
          wr_en   = 1'b1;
          wr_idx  = {addr_q[IDX_W-1:LINE_SHIFT], cnt_q};
          wr_tag  = {addr_q[TAG_W-1:LINE_SHIFT], cnt_q, 2'b00};
          wr_data = mem_data;
          if (cnt_q == addr_q[LINE_SHIFT-1:2]) resp_d = mem_data;
          if (&cnt_q) state_d = ST_RESPOND;
          else        cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_BYPASS: begin
        mem_req = 1'b1;
        if (mem_valid) begin
          resp_d  = mem_data;
          state_d = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        fetch_ready = 1'b1;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WIPE;
      cnt_q   <= '0;
      addr_q  <= '0;
      resp_q  <= '0;
      wipe_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      resp_q  <= resp_d;
      wipe_q  <= wipe_d;
      pend_q  <= pend_d;
    end
  end

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> !fetch_ready);

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_bypass_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !req_cacheable) |-> (mem_addr == req_addr));

  assert_wipe_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIPE && !(&wipe_q)) |=>
      (state_q == ST_WIPE && wipe_q == $past(wipe_q) + 1'b1));
endmodule

// File: rtl/fetch_word_cache.sv
module fetch_word_cache
  import fwc_pkg::*;
#(
  parameter int P_ADDR_W     = ADDR_W,
  parameter int P_DATA_W     = DATA_W,
  parameter int P_IDX_W      = IDX_W,
  parameter int P_TAG_W      = TAG_W,
  parameter int P_LINE_WORDS = LINE_WORDS,
  parameter int NUM_REGIONS  = 2,
  parameter logic [NUM_REGIONS*8-1:0] REGION_LIST = 16'h8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_valid,
  input  logic [P_ADDR_W-1:0]   fetch_addr,
  output logic                  fetch_ready,
  output logic [P_DATA_W-1:0]   fetch_data,
  input  logic                  flush_req,
  output logic                  mem_req,
  output logic [P_ADDR_W-1:0]   mem_addr,
  input  logic                  mem_valid,
  input  logic [P_DATA_W-1:0]   mem_data
);
  localparam int WIDX_W = P_IDX_W - 2;

  logic [1:0]          rst_sync;
  logic                core_rst_n;
  logic [P_ADDR_W-1:0] req_addr;
  logic                req_cacheable;
  logic                rd_en, wr_en;
  logic [WIDX_W-1:0]   rd_idx, wr_idx;
  logic [P_TAG_W-1:0]  rd_tag, wr_tag;
  logic [P_DATA_W-1:0] rd_data, wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  fwc_region #(
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_LIST (REGION_LIST)
  ) u_region (
    .top_byte  (req_addr[P_ADDR_W-1 -: 8]),
    .cacheable (req_cacheable)
  );

  fwc_store #(
    .WIDX_W (WIDX_W),
    .TAG_W  (P_TAG_W),
    .DATA_W (P_DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_tag  (rd_tag),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_data (wr_data)
  );

  fwc_seq #(
    .ADDR_W     (P_ADDR_W),
    .DATA_W     (P_DATA_W),
    .IDX_W      (P_IDX_W),
    .TAG_W      (P_TAG_W),
    .LINE_WORDS (P_LINE_WORDS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_addr    (fetch_addr),
    .fetch_ready   (fetch_ready),
    .fetch_data    (fetch_data),
    .flush_req     (flush_req),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_valid     (mem_valid),
    .mem_data      (mem_data),
    .req_addr      (req_addr),
    .req_cacheable (req_cacheable),
    .rd_en         (rd_en),
    .rd_idx        (rd_idx),
    .rd_tag        (rd_tag),
    .rd_data       (rd_data),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_tag        (wr_tag),
    .wr_data       (wr_data)
  );
endmodule

// File: tb/fetch_word_cache_tb.sv
module fetch_word_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIPE_CYC   = 1024;
  localparam int NVEC       = 13;
  // {kind[1:0], fetch address, address whose memory word is expected}
  // kind: 0 hit, 1 cacheable miss, 2 uncached read
  localparam logic [65:0] VEC [NVEC] = '{
    {2'd1, 32'h0000_1008, 32'h0000_1008},  // R3 R4 miss, word in middle of line
    {2'd0, 32'h0000_1000, 32'h0000_1000},  // R5 hit on line base
    {2'd0, 32'h0000_100C, 32'h0000_100C},  // R5 hit on last word
    {2'd0, 32'h8000_1004, 32'h0000_1004},  // R6 alias 0x80 -> stored 0x00 copy
    {2'd1, 32'h8000_2010, 32'h8000_2010},  // R2 region 0x80 caches
    {2'd0, 32'h0000_2014, 32'h8000_2014},  // R6 alias 0x00 -> stored 0x80 copy
    {2'd1, 32'h0000_5008, 32'h0000_5008},  // R7 conflict on slot of 0x1008
    {2'd1, 32'h0000_1008, 32'h0000_1008},  // R7 evicted line refills
    {2'd2, 32'hA000_1000, 32'hA000_1000},  // R8 tag stored but region uncached
    {2'd2, 32'h1F00_100C, 32'h1F00_100C},  // R2 R8 other top byte
    {2'd0, 32'h0000_1000, 32'h0000_1000},  // R8 uncached reads left slots alone
    {2'd2, 32'hBFC0_0100, 32'hBFC0_0100},  // R2 uncached
    {2'd1, 32'h00C0_0100, 32'h00C0_0100}   // R2 high tag bits in region 0x00
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fetch_ready;
  logic [31:0] fetch_data;
  logic        flush_req;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_data;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [31:0] log_addr [8];
  int          log_n;
  int          wait_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_word_cache u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .fetch_data  (fetch_data),
    .flush_req   (flush_req),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .mem_data    (mem_data)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16]} ^ 32'h0F1E_2D3C;
  endfunction

  // Memory: answers each held request one cycle after it is seen.
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 1) begin
        mem_valid <= 1'b1;
        mem_data  <= model(mem_addr);
        if (log_n < 8) log_addr[log_n] = mem_addr;
        log_n    = log_n + 1;
        wait_cnt = 0;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, output logic [31:0] d,
                          output int n, output int cyc);
    fetch_addr  = a;
    fetch_valid = 1'b1;
    log_n       = 0;
    cyc         = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!fetch_ready && cyc < 5000);
    d           = fetch_data;
    n           = log_n;
    fetch_valid = 1'b0;
  endtask

  task automatic check_line(input logic [31:0] a, input string req);
    for (int k = 0; k < 4; k++)
      check(log_addr[k] == ({a[31:4], 4'h0} + 32'(4*k)), req, "refill read address",
            log_addr[k], {a[31:4], 4'h0} + 32'(4*k));
  endtask

  initial begin
    #(200000*CLK_PERIOD);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int          n, cyc;
    rst_n       = 1'b0;
    fetch_valid = 1'b0;
    fetch_addr  = '0;
    flush_req   = 1'b0;
    mem_valid   = 1'b0;
    mem_data    = '0;
    log_n       = 0;
    wait_cnt    = 0;
    repeat (3) @(negedge clk);
    // R1 outputs idle under reset
    check(fetch_ready == 1'b0, "R1", "fetch_ready in reset", 32'(fetch_ready), 32'h0);
    check(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R10: fetch raised during post-reset wipe
    do_fetch(32'h0000_3000, d, n, cyc);
    check(cyc > WIPE_CYC, "R10", "cycles waited during wipe", 32'(cyc), 32'(WIPE_CYC + 1));
    check(n == 4, "R1", "reads after reset", 32'(n), 32'd4);
    check(d == model(32'h0000_3000), "R1", "data after reset", d, model(32'h0000_3000));

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  kind;
      logic [31:0] a, src;
      kind = VEC[i][65:64];
      a    = VEC[i][63:32];
      src  = VEC[i][31:0];
      @(negedge clk);
      do_fetch(a, d, n, cyc);
      check(d == model(src), "R4", "returned word", d, model(src));
      case (kind)
        2'd0: begin
          check(n == 0, "R5", "reads on hit", 32'(n), 32'd0);
          check(cyc == 1, "R5", "hit latency", 32'(cyc), 32'd1);
        end
        2'd1: begin
          check(n == 4, "R3", "reads on miss", 32'(n), 32'd4);
          check_line(a, "R3");
        end
        default: begin
          check(n == 1, "R8", "reads on uncached", 32'(n), 32'd1);
          check(log_addr[0] == a, "R8", "uncached address", log_addr[0], a);
        end
      endcase
    end

    // R9: flush then a previously cached word misses
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    do_fetch(32'h0000_1000, d, n, cyc);
    check(n == 4, "R9", "reads after flush", 32'(n), 32'd4);
    check(cyc > WIPE_CYC - 2, "R10", "wait after flush", 32'(cyc), 32'(WIPE_CYC));
    check(d == model(32'h0000_1000), "R9", "data after flush", d, model(32'h0000_1000));

    // R9: flush raised during an in-flight uncached read is remembered
    @(negedge clk);
    fork
      do_fetch(32'hA000_0040, d, n, cyc);
      begin
        @(negedge clk);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
      end
    join
    check(d == model(32'hA000_0040), "R8", "uncached word", d, model(32'hA000_0040));
    @(negedge clk);
    do_fetch(32'h0000_1004, d, n, cyc);
    check(n == 4, "R9", "reads after deferred flush", 32'(n), 32'd4);
    check_line(32'h0000_1004, "R9");
    @(negedge clk);
    do_fetch(32'h0000_1008, d, n, cyc);
    check(n == 0, "R5", "hit after refill", 32'(n), 32'd0);
    check(d == model(32'h0000_1008), "R5", "hit data", d, model(32'h0000_1008));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule